// File: doc/BRIEF.md
# Posted-Write Real-Time Clock

This block is a real-time clock that sits on a simple two-phase peripheral bus (setup phase, then access phase). A slow timekeeping clock, nominally 32.768 kHz, runs a millisecond counter and a seconds counter. A fractional divider makes the millisecond tick, so consecutive ticks are 32 or 33 slow cycles apart. The seconds counter drives one alarm comparator. Its event is recorded in an interrupt status register, and a mask register selects which status bits raise the single active-high level interrupt.

All timekeeping state lives in the slow domain. A bus write does not update a register directly. It is captured on the bus side and carried into the slow domain by a toggle request, and it is acknowledged back. While a write is on its way, a busy flag is set, and any further write is dropped. Software polls the busy flag before it writes. The bus reads a copy of the slow-domain state that is refreshed on every slow cycle. A read of the milliseconds value also freezes the seconds value from that same copy into a shadow register, so the two reads form a coherent pair.

Top module: `rtc_posted`

## Requirements
- R1: After reset, the seconds, milliseconds, shadow, alarm, mask and status registers read 0, the busy flag reads 0 and the interrupt is low.
- R2: An accepted write sets the busy flag (bit 0 at offset 0x04) from the next bus cycle. The flag stays set until the slow domain has committed the write. Reads never set it.
- R3: A write issued while busy is 1 is dropped, and the register it targets keeps its previous value.
- R4: The milliseconds value counts from 0 up to MS_PER_SEC-1 and then wraps to 0. The seconds value increments by one on that wrap and changes in no other way except by a write.
- R5: Millisecond ticks are spaced floor(SLOW_HZ/TICK_HZ) or that value plus one slow cycles apart, so elapsed time tracks TICK_HZ ticks per SLOW_HZ slow cycles.
- R6: A write to seconds (offset 0x08) loads the written value, clears the milliseconds value, and restarts the divider phase.
- R7: A read of milliseconds (offset 0x10) latches the seconds value from the same copy into the shadow register (offset 0x0C). The shadow register keeps that value until the next milliseconds read.
- R8: Status bit 0 is set on the slow edge where the seconds counter steps to a value equal to a nonzero alarm (offset 0x14). An alarm value of 0 never sets it.
- R9: A write to status (offset 0x2C, bits 4:0) clears exactly the bits that are 1 in the written data and leaves the other bits unchanged.
- R10: The interrupt output is high exactly while some status bit and the mask bit at the same position (offset 0x28, bits 4:0) are both 1. Bit 0 is the seconds alarm.
- R11: Reads of addresses outside the seven defined offsets return 0.
- R12: Once busy reads 0 after a write, a read of the written register returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| rtc_clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access phase |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions assume the bus clock runs at least about four times faster than the slow clock, so that every published copy is captured before it changes. They also assume that reset leaves both domains together and that bus accesses always pass through a setup phase before the access phase. The bench uses a slow period of eight bus cycles and reduced divider parameters (10 slow cycles per 3 ticks, 8 ticks per second), so that second rollovers and alarms happen within a short run. Its timing checks allow a tolerance of two ticks to cover the uncertainty of the synchronisers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 5;
  localparam int MS_W   = 16;
  localparam int IRQ_ALARM0 = 0;

  localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSEC   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h2C;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_SEC   = 3'd1,
    TGT_ALARM = 3'd2,
    TGT_MASK  = 3'd3,
    TGT_STAT  = 3'd4
  } wr_tgt_e;

  typedef struct packed {
    logic              ack;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] alarm;
    logic [MS_W-1:0]   msec;
    logic [IRQ_W-1:0]  mask;
    logic [IRQ_W-1:0]  stat;
  } snap_t;

  function automatic wr_tgt_e decode_wr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_SEC:   return TGT_SEC;
      OFS_ALARM: return TGT_ALARM;
      OFS_MASK:  return TGT_MASK;
      OFS_STAT:  return TGT_STAT;
      default:   return TGT_NONE;
    endcase
  endfunction

  function automatic logic tick_now(input logic [31:0] acc, input logic [31:0] step,
                                    input logic [31:0] modulus);
    return (acc + step) >= modulus;
  endfunction

  function automatic logic [31:0] acc_next(input logic [31:0] acc, input logic [31:0] step,
                                           input logic [31:0] modulus);
    logic [31:0] sum;
    sum = acc + step;
    return (sum >= modulus) ? (sum - modulus) : sum;
  endfunction

  function automatic logic [IRQ_W-1:0] clear_set(input logic [IRQ_W-1:0] old,
                                                 input logic [IRQ_W-1:0] clr,
                                                 input logic [IRQ_W-1:0] set);
    return (old & ~clr) | set;
  endfunction

  function automatic logic alarm_hit(input logic [DATA_W-1:0] sec_new,
                                     input logic [DATA_W-1:0] alarm,
                                     input logic stepped);
    return stepped && (alarm != '0) && (sec_new == alarm);
  endfunction
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_pkg::*;
#(
  parameter int SLOW_HZ    = 32768,
  parameter int TICK_HZ    = 1000,
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  wr_tgt_e           wr_tgt,
  input  logic [DATA_W-1:0] wr_data,
  output snap_t             snap_q,
  output logic              pub_tgl,
  output logic              irq
);
  localparam logic [31:0] STEP    = 32'(TICK_HZ);
  localparam logic [31:0] MODULUS = 32'(SLOW_HZ);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);
  localparam int GAP_LO = SLOW_HZ / TICK_HZ;
  localparam int GAP_HI = GAP_LO + 1;

  logic              req_s, req_seen;
  logic [31:0]       acc;
  logic [MS_W-1:0]   msec;
  logic [DATA_W-1:0] sec, alarm;
  logic [IRQ_W-1:0]  mask, stat;

  logic              commit, commit_sec, commit_alarm, commit_mask, commit_stat;
  logic              tick, wrap, hit;
  logic [31:0]       acc_n;
  logic [MS_W-1:0]   msec_n;
  logic [DATA_W-1:0] sec_n, alarm_n;
  logic [IRQ_W-1:0]  mask_n, stat_n, clr_bits, set_bits;

  rtc_sync2 #(.W(1)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

  always_comb begin
    commit       = (req_s != req_seen);
    commit_sec   = commit && (wr_tgt == TGT_SEC);
    commit_alarm = commit && (wr_tgt == TGT_ALARM);
    commit_mask  = commit && (wr_tgt == TGT_MASK);
    commit_stat  = commit && (wr_tgt == TGT_STAT);

    tick = tick_now(acc, STEP, MODULUS);
    wrap = tick && (msec == MS_LAST);

    acc_n  = commit_sec ? '0 : acc_next(acc, STEP, MODULUS);
    msec_n = commit_sec ? '0 : (wrap ? '0 : (tick ? msec + 1'b1 : msec));
    sec_n  = commit_sec ? wr_data : (wrap ? sec + 1'b1 : sec);
    hit    = alarm_hit(sec_n, alarm, wrap && !commit_sec);

    alarm_n  = commit_alarm ? wr_data : alarm;
    mask_n   = commit_mask ? wr_data[IRQ_W-1:0] : mask;
    clr_bits = commit_stat ? wr_data[IRQ_W-1:0] : '0;
    set_bits = '0;
    set_bits[IRQ_ALARM0] = hit;
    stat_n   = clear_set(stat, clr_bits, set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      acc      <= '0;
      msec     <= '0;
      sec      <= '0;
      alarm    <= '0;
      mask     <= '0;
      stat     <= '0;
      snap_q   <= '0;
      pub_tgl  <= 1'b0;
    end else begin
      req_seen <= req_s;
      acc      <= acc_n;
      msec     <= msec_n;
      sec      <= sec_n;
      alarm    <= alarm_n;
      mask     <= mask_n;
      stat     <= stat_n;
      snap_q   <= '{ack: req_s, sec: sec_n, alarm: alarm_n, msec: msec_n,
                    mask: mask_n, stat: stat_n};
      pub_tgl  <= ~pub_tgl;
    end
  end

  assign irq = |(stat & mask);

  // tick-gap checker state for the divider requirement
  int   gap_cnt;
  logic gap_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= 0;
      gap_armed <= 1'b0;
    end else if (commit_sec) begin
      gap_cnt   <= 0;
      gap_armed <= 1'b0;
    end else if (tick) begin
      gap_cnt   <= 0;
      gap_armed <= 1'b1;
    end else begin
      gap_cnt   <= gap_cnt + 1;
    end
  end

  assert_ms_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msec <= MS_LAST);

  assert_sec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_sec && !(tick && msec == MS_LAST)) |=> $stable(sec));

  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap_armed && !commit_sec) |-> (gap_cnt + 1 >= GAP_LO && gap_cnt + 1 <= GAP_HI));

  assert_alarm_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_stat && !stat[IRQ_ALARM0]) ##1 stat[IRQ_ALARM0] |-> (sec == alarm && alarm != '0));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_stat && !hit) |=> ((stat & $past(wr_data[IRQ_W-1:0])) == '0));

  assert_w1c_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stat |=> ((stat & ~$past(wr_data[IRQ_W-1:0])) == ($past(stat) & ~$past(wr_data[IRQ_W-1:0]))));
endmodule

// File: rtl/rtc_bus_side.sv
module rtc_bus_side
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              pub_tgl,
  input  snap_t             snap_in,
  output logic              req_tgl,
  output wr_tgt_e           wr_tgt,
  output logic [DATA_W-1:0] wr_data
);
  logic              pub_f, pub_seen, capture;
  snap_t             copy;
  logic [DATA_W-1:0] shadow;
  logic              busy, acc_wr, wr_accept, rd_msec, rd_phase;

  rtc_sync2 #(.W(1)) u_pub_sync (.clk(clk), .rst_n(rst_n), .d(pub_tgl), .q(pub_f));

  always_comb begin
    capture   = (pub_f != pub_seen);
    busy      = (req_tgl != copy.ack);
    acc_wr    = psel && penable && pwrite;
    wr_accept = acc_wr && !busy;
    rd_phase  = psel && !pwrite;
    rd_msec   = rd_phase && penable && (paddr == OFS_MSEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_seen <= 1'b0;
      copy     <= '0;
      shadow   <= '0;
      req_tgl  <= 1'b0;
      wr_tgt   <= TGT_NONE;
      wr_data  <= '0;
    end else begin
      pub_seen <= pub_f;
      if (capture) copy <= snap_in;
      if (rd_msec) shadow <= copy.sec;
      if (wr_accept) begin
        req_tgl <= ~req_tgl;
        wr_tgt  <= decode_wr(paddr);
        wr_data <= pwdata;
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_phase) begin
      case (paddr)
        OFS_BUSY:   prdata = DATA_W'(busy);
        OFS_SEC:    prdata = copy.sec;
        OFS_SHADOW: prdata = shadow;
        OFS_MSEC:   prdata = DATA_W'(copy.msec);
        OFS_ALARM:  prdata = copy.alarm;
        OFS_MASK:   prdata = DATA_W'(copy.mask);
        OFS_STAT:   prdata = DATA_W'(copy.stat);
        default:    prdata = '0;
      endcase
    end
  end

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy ##1 busy) |-> $past(wr_accept));

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !capture) |=> busy);

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && busy) |=> ($stable(wr_data) && $stable(req_tgl)));

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_msec |=> (shadow == $past(copy.sec)));

  assert_shadow_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msec |=> $stable(shadow));
endmodule

// File: rtl/rtc_posted.sv
module rtc_posted
  import rtc_pkg::*;
#(
  parameter int SLOW_HZ    = 32768,
  parameter int TICK_HZ    = 1000,
  parameter int MS_PER_SEC = 1000
) (
  input  logic        bus_clk,
  input  logic        rtc_clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq
);
  logic              req_tgl, pub_tgl;
  wr_tgt_e           wr_tgt;
  logic [DATA_W-1:0] wr_data;
  snap_t             snap;

  rtc_bus_side u_bus (
    .clk(bus_clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .pub_tgl(pub_tgl), .snap_in(snap),
    .req_tgl(req_tgl), .wr_tgt(wr_tgt), .wr_data(wr_data)
  );

  rtc_slow_core #(
    .SLOW_HZ(SLOW_HZ), .TICK_HZ(TICK_HZ), .MS_PER_SEC(MS_PER_SEC)
  ) u_core (
    .clk(rtc_clk), .rst_n(rst_n),
    .req_tgl(req_tgl), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .snap_q(snap), .pub_tgl(pub_tgl), .irq(irq)
  );

  assert_irq_source_R10: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    $rose(irq) |-> (snap.stat != '0));
endmodule

// File: tb/sim_rtc_posted.sv
`timescale 1ns/1ps
module sim_rtc_posted;
  localparam int SLOW_HZ = 10;
  localparam int TICK_HZ = 3;
  localparam int MPS     = 8;
  localparam int BUS_PER_SLOW = 8;
  localparam int WD_LIMIT = 150000;

  logic        bus_clk = 0, rtc_clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0, failures = 0, cyc = 0;

  rtc_posted #(.SLOW_HZ(SLOW_HZ), .TICK_HZ(TICK_HZ), .MS_PER_SEC(MPS)) u0 (
    .bus_clk(bus_clk), .rtc_clk(rtc_clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #5  bus_clk = ~bus_clk;
  always #40 rtc_clk = ~rtc_clk;

  always @(posedge bus_clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      failures = failures + 1;
      checks   = checks + 1;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_ticks(input int bus_cycles);
    return (bus_cycles * TICK_HZ) / (BUS_PER_SLOW * SLOW_HZ);
  endfunction

  function automatic int as_time(input logic [31:0] s, input logic [31:0] m);
    return int'(s) * MPS + int'(m);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge bus_clk); penable = 1;
    @(negedge bus_clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge bus_clk); penable = 1; #1 d = prdata;
    @(negedge bus_clk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] b;
    int n;
    n = 0;
    b = 1;
    while (b[0] && n < 400) begin
      bus_rd(8'h04, b);
      n++;
    end
    if (b[0]) chk(1'b0, req, b, 32'h0);
  endtask

  logic [31:0] v, v2, s0, m0, s1, m1, al;
  int t0, t1, c0, c1, d, e;

  initial begin
    v = $urandom(32'd4242);
    repeat (4) @(negedge bus_clk);
    rst_n = 1;
    repeat (4) @(negedge bus_clk);

    // R1 reset state
    foreach (s0[i]) ;
    bus_rd(8'h04, v); chk(v == 0, "R1 busy", v, 0);
    bus_rd(8'h08, v); chk(v == 0, "R1 seconds", v, 0);
    bus_rd(8'h0C, v); chk(v == 0, "R1 shadow", v, 0);
    bus_rd(8'h14, v); chk(v == 0, "R1 alarm", v, 0);
    bus_rd(8'h28, v); chk(v == 0, "R1 mask", v, 0);
    bus_rd(8'h2C, v); chk(v == 0, "R1 status", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    // R11 unmapped offsets
    bus_rd(8'h20, v); chk(v == 0, "R11 offset 0x20", v, 0);
    bus_rd(8'h00, v); chk(v == 0, "R11 offset 0x00", v, 0);

    // R2 reads never set busy
    for (int i = 0; i < 5; i++) bus_rd(8'h08 + 8'(4 * i), v);
    bus_rd(8'h04, v); chk(v == 0, "R2 busy after reads", v, 0);

    // R2 and R12 on alarm write
    bus_wr(8'h14, 32'h0000_1234);
    bus_rd(8'h04, v); chk(v == 1, "R2 busy after write", v, 1);
    wait_idle("R2 busy clears");
    bus_rd(8'h14, v); chk(v == 32'h1234, "R12 alarm readback", v, 32'h1234);

    // R3 write while busy dropped
    bus_wr(8'h28, 32'h02);
    bus_wr(8'h28, 32'h04);
    wait_idle("R3 idle");
    bus_rd(8'h28, v); chk(v == 32'h02, "R3 mask keeps first write", v, 32'h02);
    bus_wr(8'h28, 32'h00);
    wait_idle("R3 idle2");

    // R6 seconds write clears milliseconds
    bus_wr(8'h08, 32'd100);
    wait_idle("R6 idle");
    bus_rd(8'h10, m0);
    bus_rd(8'h0C, s0);
    chk(m0 <= 1, "R6 msec after seconds write", m0, 1);
    chk(s0 == 100, "R6 seconds loaded", s0, 100);

    // R4 R5 R7 timing against the bench model, random waits
    bus_rd(8'h10, m0); c0 = cyc; bus_rd(8'h0C, s0);
    for (int i = 0; i < 16; i++) begin
      repeat ($urandom_range(40, 400)) @(negedge bus_clk);
      bus_rd(8'h10, m1); c1 = cyc; bus_rd(8'h0C, s1);
      chk(m1 < MPS, "R4 msec range", m1, MPS - 1);
      t0 = as_time(s0, m0); t1 = as_time(s1, m1);
      d = t1 - t0; e = exp_ticks(c1 - c0);
      chk(d >= e - 2 && d <= e + 2, "R5 elapsed ticks", 32'(d), 32'(e));
      s0 = s1; m0 = m1; c0 = c1;
    end

    // R7 shadow frozen across a rollover
    bus_rd(8'h10, m0); bus_rd(8'h0C, s0);
    repeat (600) @(negedge bus_clk);
    bus_rd(8'h0C, s1); chk(s1 == s0, "R7 shadow held", s1, s0);
    bus_rd(8'h08, v);  chk(v > s0, "R7 seconds moved on", v, s0 + 1);

    // R8 R10 alarm fires at cur+2
    bus_rd(8'h08, v);
    al = v + 2;
    bus_wr(8'h14, al); wait_idle("R8 idle");
    bus_wr(8'h28, 32'h01); wait_idle("R8 idle2");
    bus_rd(8'h08, v); chk(v < al, "R8 before alarm", v, al);
    chk(irq == 0, "R10 irq low before alarm", 32'(irq), 0);
    d = 0;
    while (!irq && d < 3000) begin @(negedge bus_clk); d++; end
    chk(irq == 1, "R8 irq raised", 32'(irq), 1);
    repeat (10) @(negedge bus_clk);
    bus_rd(8'h08, v);  chk(v == al, "R8 seconds at alarm", v, al);
    bus_rd(8'h2C, v2); chk(v2 == 1, "R8 status bit0", v2, 1);

    // R10 masking
    bus_wr(8'h28, 32'h1E); wait_idle("R10 idle");
    chk(irq == 0, "R10 masked irq", 32'(irq), 0);
    bus_rd(8'h2C, v); chk(v == 1, "R10 status kept while masked", v, 1);
    bus_wr(8'h28, 32'h01); wait_idle("R10 idle2");
    chk(irq == 1, "R10 unmasked irq", 32'(irq), 1);

    // R9 clear-by-write
    bus_wr(8'h2C, 32'h1E); wait_idle("R9 idle");
    bus_rd(8'h2C, v); chk(v == 1, "R9 other bits leave bit0", v, 1);
    chk(irq == 1, "R9 irq still high", 32'(irq), 1);
    bus_wr(8'h2C, 32'h01); wait_idle("R9 idle2");
    bus_rd(8'h2C, v); chk(v == 0, "R9 bit0 cleared", v, 0);
    chk(irq == 0, "R9 irq dropped", 32'(irq), 0);

    // R8 alarm value 0 never matches, even through a seconds wrap to 0
    bus_wr(8'h14, 32'h0); wait_idle("R8z idle");
    bus_wr(8'h08, 32'hFFFF_FFFF); wait_idle("R8z idle2");
    repeat (400) @(negedge bus_clk);
    bus_rd(8'h08, v); chk(v <= 1, "R4 seconds wrap to 0", v, 0);
    bus_rd(8'h2C, v); chk(v == 0, "R8 zero alarm silent", v, 0);
    chk(irq == 0, "R8 zero alarm irq", 32'(irq), 0);

    // R12 random register traffic (status stays 0 so irq stays low)
    for (int i = 0; i < 8; i++) begin
      v2 = $urandom;
      bus_wr(8'h28, {27'b0, v2[4:0]}); wait_idle("R12 idle");
      bus_rd(8'h28, v); chk(v == {27'b0, v2[4:0]}, "R12 mask random", v, {27'b0, v2[4:0]});
      chk(irq == 0, "R10 irq with clear status", 32'(irq), 0);
      v2 = $urandom | 32'h8000_0000;
      bus_wr(8'h14, v2); wait_idle("R12 idle2");
      bus_rd(8'h14, v); chk(v == v2, "R12 alarm random", v, v2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule